// File: doc/BRIEF.md
# CRC-Checked I2C Register Target

This block is an I2C target that answers a single 7-bit bus address, which is set by a parameter, and holds a bank of 64 eight-bit registers. Each transfer is protected by a CRC-8. The CRC covers a short header: the device address shifted left with the direction bit in bit 0, then the register index. The data byte comes after the header. SCL and SDA enter through a two-stage synchroniser. The block pulls SDA low through a drive-enable output. It does not stretch the clock.

A controller writes a register with a START, the address byte with the write direction, and then four bytes: the register index, the data, the CRC of that write, and one filler byte whose value is ignored. The target acknowledges all four bytes. It commits the write at the STOP, and only if all four arrived, the index is in range and the CRC matches. If a check fails, the register keeps its value and a sticky error flag is set. A read is an index-only write, a repeated START and the address byte with the read direction. The target then returns the register value followed by a CRC computed over the read-direction header and that value. A side port lets any register be observed directly.

Top module: `crc_i2c_target`

## Requirements
- R1: The CRC is CRC-8 with generator 0x07 and start value 0x00. Bits are taken most significant first and no final XOR is applied.
- R2: Only the address byte `{DEV_ADDR, rw}` is acknowledged. A transaction to any other address gets no ACK on any byte and changes no register or flag.
- R3: A write frame of address, index, data, CRC and filler has all five bytes acknowledged. At the STOP, a good frame stores the data in register `index[5:0]`. A good frame has a CRC equal to CRC over `{DEV_ADDR,0}`, index, data.
- R4: A four-byte write with an in-range index and a wrong CRC leaves every register unchanged and sets `crc_err`. The flag then stays set until it is cleared.
- R5: An index byte with bit 7 or bit 6 set is out of range. A four-byte write with such an index changes no register and sets the sticky `idx_err`. A read of such an index returns data 0x00.
- R6: After an index-only write, a repeated START and `{DEV_ADDR,1}`, the target sends the addressed register value. It then sends CRC over `{DEV_ADDR,1}`, index, value, both bytes MSB first.
- R7: A NACK from the controller after the data byte or after the CRC byte makes the target release SDA. It does not drive SDA again until the next START.
- R8: `err_clr` high for a cycle clears both `crc_err` and `idx_err`. Clearing takes priority over a flag being set in the same cycle.
- R9: After reset all 64 registers read zero, both flags are low and SDA is released.
- R10: A write that ends at a STOP or repeated START after fewer than four data bytes commits nothing and sets no flag.
- R11: A fifth data byte in a write is not acknowledged and the whole frame is discarded without setting a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sensed SCL level |
| sda_i | input | 1 | Sensed SDA level |
| sda_oe | output | 1 | High pulls SDA low |
| err_clr | input | 1 | Clears both error flags |
| crc_err | output | 1 | Sticky CRC mismatch flag |
| idx_err | output | 1 | Sticky out-of-range index flag |
| peek_idx | input | IDX_W | Register index for the side read port |
| peek_data | output | 8 | Combinational value of register `peek_idx` |

## Verification
The hardest situations to reach from the pins are the frames that are almost correct. These are a CRC with a single flipped bit, an index that is in range in its low six bits but has a top bit set, and frames cut short or run one byte long. Each of them must leave the register file untouched. The stimulus builds them on purpose: single-bit corruption of the bench-computed CRC, index bytes with random upper bits, frames of two and five bytes, and a read that the controller NACKs after the data byte. The side port then confirms that the register aliased by the low six index bits did not change. Random writes and reads, driven from a fixed seed, are mixed in and checked against a bench register model and a bit-serial CRC.

// File: rtl/ci2c_pkg.sv
package ci2c_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_RX, S_ACK, S_TX, S_MACK, S_DONE
  } bus_state_t;

  localparam logic [7:0] CRC_POLY = 8'h07;

  // one byte through the CRC-8 register, MSB first
  function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] r;
    r = c ^ b;
    for (int i = 0; i < 8; i++) begin
      r = r[7] ? ({r[6:0], 1'b0} ^ CRC_POLY) : {r[6:0], 1'b0};
    end
    return r;
  endfunction

  // header (address + direction, index) followed by the data byte
  function automatic logic [7:0] crc8_hdr(input logic [6:0] dev, input logic rw,
                                          input logic [7:0] idx, input logic [7:0] dat);
    return crc8_step(crc8_step(crc8_step(8'h00, {dev, rw}), idx), dat);
  endfunction

endpackage

// File: rtl/ci2c_line_sync.sv
module ci2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d, scl_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_d  <= scl_ff[STAGES-1];
      sda_d  <= sda_ff[STAGES-1];
    end
  end

  assign scl_now   = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_now & ~scl_d;
  assign scl_fall  = ~scl_now & scl_d;
  assign start_det = scl_now & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_now & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/ci2c_frame_check.sv
module ci2c_frame_check
  import ci2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h64,
  parameter int         IDX_W       = 6,
  parameter int         FRAME_BYTES = 4,
  parameter int         CNT_W       = 3
) (
  input  logic             stop,
  input  logic [CNT_W-1:0] nbytes,
  input  logic [7:0]       idx,
  input  logic [7:0]       dat,
  input  logic [7:0]       crc_rx,
  output logic             wr_en,
  output logic             crc_set,
  output logic             idx_set
);
  logic full, idx_ok, crc_ok;

  assign full    = stop && (nbytes == CNT_W'(FRAME_BYTES));
  assign idx_ok  = (idx[7:IDX_W] == '0);
  assign crc_ok  = (crc8_hdr(DEV_ADDR, 1'b0, idx, dat) == crc_rx);
  assign wr_en   = full && idx_ok && crc_ok;
  assign idx_set = full && !idx_ok;
  assign crc_set = full && idx_ok && !crc_ok;
endmodule

// File: rtl/ci2c_regfile.sv
module ci2c_regfile #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [7:0]       wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [7:0]       rdata,
  input  logic [IDX_W-1:0] paddr,
  output logic [7:0]       pdata
);
  localparam int DEPTH = 1 << IDX_W;
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
  assign pdata = mem[paddr];
endmodule

// File: rtl/crc_i2c_target.sv
module crc_i2c_target
  import ci2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h64,
  parameter int         IDX_W       = 6,
  parameter int         FRAME_BYTES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  input  logic             err_clr,
  output logic             crc_err,
  output logic             idx_err,
  input  logic [IDX_W-1:0] peek_idx,
  output logic [7:0]       peek_data
);
  localparam int CNT_W = $clog2(FRAME_BYTES + 2);

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic wr_en, crc_set, idx_set, quiet;
  bus_state_t st;
  logic [3:0]       bitc;
  logic [7:0]       sh, tx_sh, tx_dat;
  logic [7:0]       idx_q, dat_q, crc_q;
  logic [CNT_W-1:0] nbytes;
  logic             to_tx, crc_phase, mack;
  logic [7:0]       rf_rd, rd_byte, rd_crc;
  logic             idx_ok;

  ci2c_line_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  ci2c_frame_check #(.DEV_ADDR(DEV_ADDR), .IDX_W(IDX_W), .FRAME_BYTES(FRAME_BYTES),
                     .CNT_W(CNT_W)) u_fchk (
    .stop(stop_det), .nbytes(nbytes), .idx(idx_q), .dat(dat_q), .crc_rx(crc_q),
    .wr_en(wr_en), .crc_set(crc_set), .idx_set(idx_set)
  );

  ci2c_regfile #(.IDX_W(IDX_W)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(wr_en), .waddr(idx_q[IDX_W-1:0]), .wdata(dat_q),
    .raddr(idx_q[IDX_W-1:0]), .rdata(rf_rd), .paddr(peek_idx), .pdata(peek_data)
  );

  assign idx_ok  = (idx_q[7:IDX_W] == '0);
  assign rd_byte = idx_ok ? rf_rd : 8'h00;
  assign rd_crc  = crc8_hdr(DEV_ADDR, 1'b1, idx_q, tx_dat);
  assign quiet   = (st == S_IDLE) || (st == S_DONE);

  // bus engine
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; bitc <= '0; sh <= '0; tx_sh <= '0; tx_dat <= '0;
      idx_q <= '0; dat_q <= '0; crc_q <= '0; nbytes <= '0;
      to_tx <= 1'b0; crc_phase <= 1'b0; mack <= 1'b0; sda_oe <= 1'b0;
    end else if (start_det) begin
      st <= S_ADDR; bitc <= '0; nbytes <= '0; sda_oe <= 1'b0;
    end else if (stop_det) begin
      st <= S_IDLE; nbytes <= '0; sda_oe <= 1'b0;
    end else begin
      case (st)
        S_ADDR, S_RX: begin
          if (scl_rise) begin
            sh   <= {sh[6:0], sda_s};
            bitc <= bitc + 4'd1;
          end else if (scl_fall && bitc == 4'd8) begin
            bitc <= '0;
            if (st == S_ADDR) begin
              if (sh[7:1] == DEV_ADDR) begin
                sda_oe <= 1'b1; to_tx <= sh[0]; st <= S_ACK;
              end else begin
                st <= S_IDLE;
              end
            end else begin
              case (nbytes)
                CNT_W'(0): idx_q <= sh;
                CNT_W'(1): dat_q <= sh;
                CNT_W'(2): crc_q <= sh;
                default: ;
              endcase
              if (nbytes != CNT_W'(FRAME_BYTES + 1)) nbytes <= nbytes + 1'b1;
              to_tx <= 1'b0;
              if (nbytes < CNT_W'(FRAME_BYTES)) begin
                sda_oe <= 1'b1; st <= S_ACK;
              end else begin
                st <= S_DONE;
              end
            end
          end
        end
        S_ACK: begin
          if (scl_fall) begin
            if (to_tx) begin
              tx_sh <= rd_byte; tx_dat <= rd_byte; sda_oe <= ~rd_byte[7];
              crc_phase <= 1'b0; bitc <= '0; st <= S_TX;
            end else begin
              sda_oe <= 1'b0; st <= S_RX;
            end
          end
        end
        S_TX: begin
          if (scl_fall) begin
            if (bitc == 4'd7) begin
              sda_oe <= 1'b0; bitc <= '0; st <= S_MACK;
            end else begin
              tx_sh  <= {tx_sh[6:0], 1'b0};
              sda_oe <= ~tx_sh[6];
              bitc   <= bitc + 4'd1;
            end
          end
        end
        S_MACK: begin
          if (scl_rise) begin
            mack <= ~sda_s;
          end else if (scl_fall) begin
            if (mack && !crc_phase) begin
              tx_sh <= rd_crc; sda_oe <= ~rd_crc[7]; crc_phase <= 1'b1;
              bitc <= '0; st <= S_TX;
            end else begin
              st <= S_DONE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // sticky flags, clear has priority
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_err <= 1'b0;
      idx_err <= 1'b0;
    end else if (err_clr) begin
      crc_err <= 1'b0;
      idx_err <= 1'b0;
    end else begin
      crc_err <= crc_err | crc_set;
      idx_err <= idx_err | idx_set;
    end
  end
endmodule

// File: rtl/crc_i2c_target_chk.sv
module crc_i2c_target_chk (
  input logic clk,
  input logic rst_n,
  input logic err_clr,
  input logic crc_err,
  input logic idx_err,
  input logic sda_oe,
  input logic wr_en,
  input logic crc_set,
  input logic idx_set,
  input logic stop_det,
  input logic quiet
);
  AST_CRC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    crc_err && !err_clr |=> crc_err); // R4
  AST_IDX_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    idx_err && !err_clr |=> idx_err); // R5
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr |=> !crc_err && !idx_err); // R8
  AST_WRITE_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> stop_det); // R3
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({wr_en, crc_set, idx_set}) <= 1); // R4
  AST_QUIET_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |-> !sda_oe); // R7
endmodule

bind crc_i2c_target crc_i2c_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .err_clr(err_clr), .crc_err(crc_err), .idx_err(idx_err),
  .sda_oe(sda_oe), .wr_en(wr_en), .crc_set(crc_set), .idx_set(idx_set),
  .stop_det(stop_det), .quiet(quiet)
);

// File: tb/sim_crc_i2c_target.sv
module sim_crc_i2c_target;
  localparam int CLK_P = 10;
  localparam int Q = 4;
  localparam logic [6:0] DEV = 7'h64;
  localparam logic [6:0] OTHER = 7'h1A;

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, m_low = 1'b0, err_clr = 1'b0;
  logic [5:0] peek_idx = '0;
  logic sda_oe, crc_err, idx_err, sda_line;
  logic [7:0] peek_data;
  int n_chk = 0, n_err = 0;
  logic [7:0] model [64];
  bit exp_ce = 0, exp_ie = 0;

  always #(CLK_P/2) clk = ~clk;
  assign sda_line = ~(m_low | sda_oe);

  crc_i2c_target u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .err_clr(err_clr), .crc_err(crc_err), .idx_err(idx_err),
    .peek_idx(peek_idx), .peek_data(peek_data)
  );

  // bit-serial reference CRC (R1)
  function automatic logic [7:0] ref_crc(input logic [23:0] msg);
    logic [7:0] c;
    logic fb;
    c = 8'h00;
    for (int i = 23; i >= 0; i--) begin
      fb = c[7] ^ msg[i];
      c = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return c;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    if (!scl_m) begin tick(Q); m_low = 1'b0; tick(Q); scl_m = 1'b1; end
    tick(2*Q); m_low = 1'b1; tick(2*Q); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    tick(Q); m_low = 1'b1; tick(Q); scl_m = 1'b1; tick(2*Q); m_low = 1'b0; tick(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      tick(Q); m_low = ~b[i]; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0;
    end
    tick(Q); m_low = 1'b0; tick(Q); scl_m = 1'b1; tick(Q);
    ack = ~sda_line; tick(Q); scl_m = 1'b0;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      tick(Q); m_low = 1'b0; tick(Q); scl_m = 1'b1; tick(Q);
      b[i] = sda_line; tick(Q); scl_m = 1'b0;
    end
    tick(Q); m_low = give_ack; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0;
  endtask

  task automatic wr_txn(input logic [6:0] a, input logic [7:0] idx, input logic [7:0] d,
                        input logic [7:0] c, input int nb, output logic [5:0] acks);
    logic [7:0] bytes [5];
    bit k;
    bytes[0] = idx; bytes[1] = d; bytes[2] = c; bytes[3] = 8'hA5; bytes[4] = 8'h3C;
    acks = '0;
    bus_start();
    send_byte({a, 1'b0}, k); acks[0] = k;
    for (int i = 0; i < nb; i++) begin send_byte(bytes[i], k); acks[i+1] = k; end
    bus_stop();
  endtask

  task automatic rd_txn(input logic [7:0] idx, input bit nack_data,
                        output logic [7:0] d, output logic [7:0] c, output logic [2:0] acks);
    bit k;
    bus_start();
    send_byte({DEV, 1'b0}, k); acks[0] = k;
    send_byte(idx, k); acks[1] = k;
    bus_start();
    send_byte({DEV, 1'b1}, k); acks[2] = k;
    recv_byte(!nack_data, d);
    recv_byte(1'b0, c);
    bus_stop();
  endtask

  function automatic logic [5:0] exp_acks(input logic [6:0] a, input int nb);
    logic [5:0] r;
    r = '0;
    if (a == DEV) for (int i = 0; i <= nb && i <= 4; i++) r[i] = 1'b1;
    return r;
  endfunction

  task automatic peek(input logic [5:0] i, output logic [7:0] v);
    peek_idx = i; tick(1); v = peek_data;
  endtask

  // full write plus model update and checks
  task automatic do_write(input string req, input logic [6:0] a, input logic [7:0] idx,
                          input logic [7:0] d, input logic [7:0] c, input int nb);
    logic [5:0] acks;
    logic [7:0] v;
    wr_txn(a, idx, d, c, nb, acks);
    chk({req, " acks"}, acks, exp_acks(a, nb));
    if (a == DEV && nb == 4) begin
      if (idx[7:6] != 0) exp_ie = 1;
      else if (c != ref_crc({a, 1'b0, idx, d})) exp_ce = 1;
      else model[idx[5:0]] = d;
    end
    tick(2);
    peek(idx[5:0], v);
    chk({req, " reg"}, v, model[idx[5:0]]);
    chk({req, " flags"}, {crc_err, idx_err}, {exp_ce, exp_ie});
  endtask

  task automatic do_read(input string req, input logic [7:0] idx);
    logic [7:0] d, c, ed;
    logic [2:0] acks;
    rd_txn(idx, 1'b0, d, c, acks);
    ed = (idx[7:6] != 0) ? 8'h00 : model[idx[5:0]];
    chk({req, " acks"}, acks, 3'b111);
    chk({req, " data"}, d, ed);
    chk({req, " crc"}, c, ref_crc({DEV, 1'b1, idx, ed}));
  endtask

  task automatic clear_flags();
    err_clr = 1'b1; tick(1); err_clr = 1'b0; tick(1);
    exp_ce = 0; exp_ie = 0;
  endtask

  initial begin
    logic [7:0] v, d, c, idx;
    logic [2:0] racks;
    int bad, kind;
    bit quiet_ok;
    for (int i = 0; i < 64; i++) model[i] = 8'h00;
    void'($urandom(32'd4242));
    tick(5); rst_n = 1'b1; tick(3);

    // R9 reset state
    bad = 0;
    for (int i = 0; i < 64; i++) begin peek(6'(i), v); if (v != 0) bad++; end
    chk("R9 regs zero", bad, 0);
    chk("R9 flags and sda", {crc_err, idx_err, sda_oe}, 3'b000);

    // R3 and R1: good write, R6 read back
    do_write("R3 good write", DEV, 8'h05, 8'h3C, ref_crc({DEV, 1'b0, 8'h05, 8'h3C}), 4);
    do_read("R6 read idx5", 8'h05);
    // boundary index 63
    do_write("R3 idx63", DEV, 8'h3F, 8'hE1, ref_crc({DEV, 1'b0, 8'h3F, 8'hE1}), 4);
    do_read("R6 read idx63", 8'h3F);

    // R2 foreign address
    do_write("R2 other addr", OTHER, 8'h05, 8'h99, ref_crc({OTHER, 1'b0, 8'h05, 8'h99}), 4);

    // R4 single bit CRC error
    do_write("R4 bad crc", DEV, 8'h05, 8'h77, ref_crc({DEV, 1'b0, 8'h05, 8'h77}) ^ 8'h10, 4);
    // R8 clear
    clear_flags();
    chk("R8 flags cleared", {crc_err, idx_err}, 2'b00);

    // R5 out-of-range index aliasing register 5
    do_write("R5 bad idx", DEV, 8'h45, 8'h11, ref_crc({DEV, 1'b0, 8'h45, 8'h11}), 4);
    do_read("R5 read bad idx", 8'h85);
    clear_flags();
    chk("R8 clear idx_err", {crc_err, idx_err}, 2'b00);

    // R10 short frame, R11 long frame
    do_write("R10 short", DEV, 8'h05, 8'h22, ref_crc({DEV, 1'b0, 8'h05, 8'h22}), 2);
    do_write("R11 long", DEV, 8'h05, 8'h33, ref_crc({DEV, 1'b0, 8'h05, 8'h33}), 5);

    // R7 NACK after data byte: no CRC byte driven, bus stays released
    rd_txn(8'h3F, 1'b1, d, c, racks);
    chk("R7 data before nack", d, model[63]);
    chk("R7 no crc after nack", c, 8'hFF);
    quiet_ok = 1;
    for (int i = 0; i < 20; i++) begin tick(1); if (sda_oe) quiet_ok = 0; end
    chk("R7 released after stop", quiet_ok, 1'b1);

    // random mix
    for (int it = 0; it < 40; it++) begin
      kind = $urandom_range(0, 9);
      idx = {2'b00, 6'($urandom_range(0, 63))};
      d = 8'($urandom);
      if (kind < 4) begin
        do_write("R3 rand write", DEV, idx, d, ref_crc({DEV, 1'b0, idx, d}), 4);
      end else if (kind == 4) begin
        do_write("R4 rand bad crc", DEV, idx, d,
                 ref_crc({DEV, 1'b0, idx, d}) ^ (8'h01 << $urandom_range(0, 7)), 4);
      end else if (kind == 5) begin
        idx[7:6] = 2'($urandom_range(1, 3));
        do_write("R5 rand bad idx", DEV, idx, d, ref_crc({DEV, 1'b0, idx, d}), 4);
      end else if (kind == 6) begin
        clear_flags();
        chk("R8 rand clear", {crc_err, idx_err}, 2'b00);
      end else begin
        do_read("R6 rand read", idx);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule